// File: doc/BRIEF.md
# Dual-Clock FIFO with Asymmetric Empty Timing

This block moves words between two unrelated clock domains through a dual-port memory. One side writes, clocked by its own clock. The other side reads, clocked by a second clock whose frequency and phase have no fixed relation to the first. Each side keeps a binary position counter that is one bit wider than the memory address. A Gray-coded copy of each counter crosses into the other domain through a two-flop synchronizer.

The status flags are deliberately lopsided. The empty flag stops a reader at once: it rises on the very read edge that takes the last stored word. It drops only after a new word's write position has been carried across the synchronizer, which costs a few read-clock cycles. The full flag behaves in the same eager way on the write side: it rises on the edge that fills the final free slot, so a continuous burst loses nothing. Two warning flags, almost-full and almost-empty, compare the occupancy seen in their own domain against software-free threshold inputs with a resolution of one entry. Because one of the two positions has been carried across the synchronizer, these flags can lag the true state and err on the cautious side.

A producer checks the full flag before it writes and a consumer checks the empty flag before it reads. The almost flags give early warning, for example a 1024-deep instance with its almost-full threshold at 1020.

Top module: `dual_clock_fifo`

## Requirements
- R1: While `arst_n` is low, and after it is released until the first access, `rd_empty` and `rd_almost_empty` are 1, `wr_full` and `wr_almost_full` are 0, and `rd_data` is 0.
- R2: Words leave in the order they were accepted, with no loss or duplication. This holds while the two clocks run at unrelated rates and the producer is throttled by `wr_full`.
- R3: `wr_full` rises on the write-clock edge that stores entry number DEPTH (DEPTH = 2**ADDR_W, 512 by default), and it is 0 while 511 entries are held.
- R4: A write attempted while `wr_full` is 1 is dropped: the stored contents and their order are unchanged, and `wr_full` stays 1.
- R5: `rd_empty` rises on the read-clock edge that removes the last stored entry, and it stays 0 while at least one entry remains.
- R6: After a write into an empty FIFO, `rd_empty` stays 1 through at least the second rising `rd_clk` edge after the write edge, and it is 0 by the fourth.
- R7: A read attempted while `rd_empty` is 1 is dropped: `rd_data` holds its last value and the next word written is the next word read.
- R8: `wr_almost_full` is registered on every `wr_clk` edge as 1 when the occupancy seen in the write domain is at least `af_level` (an unsigned count of entries), and 0 otherwise.
- R9: `rd_almost_empty` is registered on every `rd_clk` edge as 1 when the occupancy seen in the read domain is at most `ae_level` (an unsigned count of entries), and 0 otherwise.
- R10: Positions cross domains in Gray code that changes by at most one bit per source-clock edge. Capacity is exactly DEPTH, and data survives position wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock, unrelated to `wr_clk` |
| arst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en | input | 1 | Request to store `wr_data` on this edge |
| wr_data | input | DATA_W | Word to store |
| af_level | input | ADDR_W+1 | Occupancy at or above which almost-full is raised |
| wr_full | output | 1 | No free entry; writes are dropped |
| wr_almost_full | output | 1 | Write-side occupancy has reached `af_level` |
| rd_en | input | 1 | Request to take the oldest word on this edge |
| ae_level | input | ADDR_W+1 | Occupancy at or below which almost-empty is raised |
| rd_data | output | DATA_W | Word taken by the most recent accepted read |
| rd_empty | output | 1 | No stored entry visible; reads are dropped |
| rd_almost_empty | output | 1 | Read-side occupancy is at or below `ae_level` |

## Verification
The bench aims at the edges where the two flags change. It checks that full is absent at DEPTH-1 and present at DEPTH: a design whose full flag lags one edge would drop the last word of a burst, and the drain would show a mismatch or a short count. It checks that empty rises on the edge of the final read and then holds for two read edges after a fresh write. A flag that fell too early would let the reader fetch a slot before its data is visible, and one that never fell would stall the stream. Reads and writes against a blocked side, threshold hits one entry either side of each level, and a long stream with pauses across pointer wrap-around show up order errors, off-by-one comparisons and pointers that moved when they should not.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  // Widest position counter the helpers handle; modules truncate to their own width.
  localparam int POS_MAX_W = 16;

  function automatic logic [POS_MAX_W-1:0] to_gray(logic [POS_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [POS_MAX_W-1:0] from_gray(logic [POS_MAX_W-1:0] g);
    logic [POS_MAX_W-1:0] b;
    b[POS_MAX_W-1] = g[POS_MAX_W-1];
    for (int i = POS_MAX_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              arst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk or negedge arst_n) begin
    if (!arst_n)  rdata <= '0;
    else if (re)  rdata <= store[raddr];
  end
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 9,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wr_clk,
  input  logic              arst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  af_level,
  input  logic [PTR_W-1:0]  rgray_sync,
  output logic              wr_take,
  output logic [ADDR_W-1:0] waddr,
  output logic [PTR_W-1:0]  wgray_q,
  output logic              full_q,
  output logic              afull_q
);
  logic [PTR_W-1:0] wbin_q, wbin_nxt, wgray_nxt;
  logic [PTR_W-1:0] rbin_sync, fill_nxt, fill_cur;
  logic [PTR_W-1:0] full_pattern;
  logic             full_nxt, afull_nxt;

  assign wr_take   = wr_en && !full_q;
  assign wbin_nxt  = wbin_q + PTR_W'(wr_take);
  assign wgray_nxt = PTR_W'(to_gray(POS_MAX_W'(wbin_nxt)));
  assign rbin_sync = PTR_W'(from_gray(POS_MAX_W'(rgray_sync)));

  // Full when the next write position is one lap ahead of the read position.
  assign full_pattern = {~rgray_sync[PTR_W-1:PTR_W-2], rgray_sync[PTR_W-3:0]};
  assign full_nxt     = (wgray_nxt == full_pattern);
  assign fill_nxt     = wbin_nxt - rbin_sync;
  assign fill_cur     = wbin_q - rbin_sync;
  assign afull_nxt    = (fill_nxt >= af_level);
  assign waddr        = wbin_q[ADDR_W-1:0];

  always_ff @(posedge wr_clk or negedge arst_n) begin
    if (!arst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wgray_nxt;
      full_q  <= full_nxt;
      afull_q <= afull_nxt;
    end
  end

  // R4
  wr_blocked_when_full_chk: assert property (@(posedge wr_clk) disable iff (!arst_n)
    full_q |=> $stable(wbin_q));

  // R3
  fill_never_exceeds_depth_chk: assert property (@(posedge wr_clk) disable iff (!arst_n)
    fill_cur <= PTR_W'(DEPTH));

  // R10
  gray_single_step_chk: assert property (@(posedge wr_clk) disable iff (!arst_n)
    $onehot0(wgray_q ^ $past(wgray_q)));

  // R8
  full_implies_almost_chk: assert property (@(posedge wr_clk) disable iff (!arst_n)
    (full_q && ($past(af_level) <= PTR_W'(DEPTH))) |-> afull_q);
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 9,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              rd_clk,
  input  logic              arst_n,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  ae_level,
  input  logic [PTR_W-1:0]  wgray_sync,
  output logic              rd_take,
  output logic [ADDR_W-1:0] raddr,
  output logic [PTR_W-1:0]  rgray_q,
  output logic              empty_q,
  output logic              aempty_q
);
  logic [PTR_W-1:0] rbin_q, rbin_nxt, rgray_nxt;
  logic [PTR_W-1:0] wbin_sync, fill_nxt, fill_cur;
  logic             empty_nxt, aempty_nxt;

  assign rd_take    = rd_en && !empty_q;
  assign rbin_nxt   = rbin_q + PTR_W'(rd_take);
  assign rgray_nxt  = PTR_W'(to_gray(POS_MAX_W'(rbin_nxt)));
  assign wbin_sync  = PTR_W'(from_gray(POS_MAX_W'(wgray_sync)));

  // Empty is decided from the position after this edge's read, so it sets at once;
  // it clears only when the synchronized write position has moved on.
  assign empty_nxt  = (rgray_nxt == wgray_sync);
  assign fill_nxt   = wbin_sync - rbin_nxt;
  assign fill_cur   = wbin_sync - rbin_q;
  assign aempty_nxt = (fill_nxt <= ae_level);
  assign raddr      = rbin_q[ADDR_W-1:0];

  always_ff @(posedge rd_clk or negedge arst_n) begin
    if (!arst_n) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
    end else begin
      rbin_q   <= rbin_nxt;
      rgray_q  <= rgray_nxt;
      empty_q  <= empty_nxt;
      aempty_q <= aempty_nxt;
    end
  end

  // R7
  rd_blocked_when_empty_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
    empty_q |=> $stable(rbin_q));

  // R5
  last_read_sets_empty_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
    (rd_take && (fill_cur == PTR_W'(1))) |=> empty_q);

  // R6
  clear_empty_has_data_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
    !empty_q |-> (fill_cur != '0));

  // R10
  rd_gray_single_step_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
    $onehot0(rgray_q ^ $past(rgray_q)));
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 9,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              arst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  af_level,
  output logic              wr_full,
  output logic              wr_almost_full,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  ae_level,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              rd_almost_empty
);
  logic              wr_take, rd_take;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wgray, rgray, wgray_in_rd, rgray_in_wr;

  dcfifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .wr_clk     (wr_clk),
    .arst_n     (arst_n),
    .wr_en      (wr_en),
    .af_level   (af_level),
    .rgray_sync (rgray_in_wr),
    .wr_take    (wr_take),
    .waddr      (waddr),
    .wgray_q    (wgray),
    .full_q     (wr_full),
    .afull_q    (wr_almost_full)
  );

  dcfifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
    .rd_clk     (rd_clk),
    .arst_n     (arst_n),
    .rd_en      (rd_en),
    .ae_level   (ae_level),
    .wgray_sync (wgray_in_rd),
    .rd_take    (rd_take),
    .raddr      (raddr),
    .rgray_q    (rgray),
    .empty_q    (rd_empty),
    .aempty_q   (rd_almost_empty)
  );

  dcfifo_sync #(.W(PTR_W)) u_w2r (
    .clk    (rd_clk),
    .arst_n (arst_n),
    .d      (wgray),
    .q      (wgray_in_rd)
  );

  dcfifo_sync #(.W(PTR_W)) u_r2w (
    .clk    (wr_clk),
    .arst_n (arst_n),
    .d      (rgray),
    .q      (rgray_in_wr)
  );

  dcfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wr_clk (wr_clk),
    .we     (wr_take),
    .waddr  (waddr),
    .wdata  (wr_data),
    .rd_clk (rd_clk),
    .arst_n (arst_n),
    .re     (rd_take),
    .raddr  (raddr),
    .rdata  (rd_data)
  );
endmodule

// File: tb/test_dual_clock_fifo.sv
`timescale 1ns/100ps
module test_dual_clock_fifo;
  localparam realtime WR_PERIOD = 10.0;
  localparam realtime RD_PERIOD = 13.0;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PTR_W  = ADDR_W + 1;

  logic              wr_clk = 1'b0, rd_clk = 1'b0, arst_n = 1'b0;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [PTR_W-1:0]  af_level = '0, ae_level = '0;
  logic              wr_full, wr_almost_full, rd_empty, rd_almost_empty;
  logic [DATA_W-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  dual_clock_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dual_clock_fifo (
    .wr_clk, .rd_clk, .arst_n, .wr_en, .wr_data, .af_level, .wr_full, .wr_almost_full,
    .rd_en, .ae_level, .rd_data, .rd_empty, .rd_almost_empty
  );

  typedef struct packed {
    logic [9:0] af;
    logic [9:0] ae;
    logic [9:0] n;
    logic       x_af;
    logic       x_ae;
    logic       x_full;
  } row_t;

  // Threshold table: levels, words written from empty, expected flags once settled.
  localparam row_t TBL [8] = '{
    '{10'd5,   10'd3, 10'd4,   1'b0, 1'b0, 1'b0},
    '{10'd5,   10'd3, 10'd5,   1'b1, 1'b0, 1'b0},
    '{10'd5,   10'd3, 10'd3,   1'b0, 1'b1, 1'b0},
    '{10'd1,   10'd0, 10'd0,   1'b0, 1'b1, 1'b0},
    '{10'd1,   10'd0, 10'd1,   1'b1, 1'b0, 1'b0},
    '{10'd508, 10'd2, 10'd507, 1'b0, 1'b0, 1'b0},
    '{10'd508, 10'd2, 10'd508, 1'b1, 1'b0, 1'b0},
    '{10'd508, 10'd2, 10'd512, 1'b1, 1'b0, 1'b1}
  };

  function automatic logic [DATA_W-1:0] pat(int i);
    return DATA_W'(i * 37 + 11);
  endfunction

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report_and_end();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic reset_all(int af, int ae);
    arst_n   = 1'b0;
    wr_en    = 1'b0;
    rd_en    = 1'b0;
    af_level = PTR_W'(af);
    ae_level = PTR_W'(ae);
    repeat (3) @(negedge wr_clk);
    arst_n = 1'b1;
    repeat (2) @(negedge wr_clk);
  endtask

  task automatic write_words(int n, int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en   = 1'b1;
      wr_data = pat(base + i);
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic read_words(int n, int base, inout int mism);
    @(negedge rd_clk);
    rd_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      if (rd_data !== pat(base + i)) mism++;
      rd_en = (i < n - 1);
    end
  endtask

  task automatic wait_rd(int k);
    repeat (k) @(negedge rd_clk);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    report_and_end();
  end

  initial begin
    int mism;

    // R1 reset state
    reset_all(4, 4);
    check_eq("R1 wr_full after reset", int'(wr_full), 0);
    check_eq("R1 wr_almost_full after reset", int'(wr_almost_full), 0);
    check_eq("R1 rd_empty after reset", int'(rd_empty), 1);
    check_eq("R1 rd_almost_empty after reset", int'(rd_almost_empty), 1);
    check_eq("R1 rd_data after reset", int'(rd_data), 0);

    // R8 R9 R3 threshold table
    foreach (TBL[r]) begin
      reset_all(int'(TBL[r].af), int'(TBL[r].ae));
      if (TBL[r].n != 0) write_words(int'(TBL[r].n), 0);
      else @(negedge wr_clk);
      check_eq($sformatf("R8 almost_full row %0d", r), int'(wr_almost_full), int'(TBL[r].x_af));
      check_eq($sformatf("R3 full row %0d", r), int'(wr_full), int'(TBL[r].x_full));
      wait_rd(6);
      check_eq($sformatf("R9 almost_empty row %0d", r), int'(rd_almost_empty), int'(TBL[r].x_ae));
    end

    // R3 R4 R10 fill to capacity, push while full, drain
    reset_all(DEPTH, 0);
    write_words(DEPTH - 1, 0);
    check_eq("R3 full clear at DEPTH-1", int'(wr_full), 0);
    write_words(1, DEPTH - 1);
    check_eq("R3 full set at DEPTH", int'(wr_full), 1);
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = 8'hEE;
    repeat (3) @(negedge wr_clk);
    wr_en = 1'b0;
    check_eq("R4 full holds after dropped writes", int'(wr_full), 1);
    wait_rd(6);
    mism = 0;
    read_words(DEPTH, 0, mism);
    check_eq("R4 contents unchanged by dropped writes", mism, 0);
    check_eq("R10 capacity exactly DEPTH then empty", int'(rd_empty), 1);

    // R5 R7 R6 empty timing
    reset_all(8, 1);
    write_words(3, 100);
    wait_rd(6);
    check_eq("R5 not empty with 3 held", int'(rd_empty), 0);
    mism = 0;
    read_words(2, 100, mism);
    check_eq("R5 not empty with 1 left", int'(rd_empty), 0);
    read_words(1, 102, mism);
    check_eq("R5 empty on last read edge", int'(rd_empty), 1);
    check_eq("R5 read data in order", mism, 0);
    @(negedge rd_clk);
    rd_en = 1'b1;
    repeat (3) @(negedge rd_clk);
    rd_en = 1'b0;
    check_eq("R7 rd_data held on empty reads", int'(rd_data), int'(pat(102)));
    check_eq("R7 still empty", int'(rd_empty), 1);
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = pat(200);
    @(posedge wr_clk);
    #0.2;
    wr_en = 1'b0;
    repeat (2) @(posedge rd_clk);
    #1;
    check_eq("R6 empty held two read edges after write", int'(rd_empty), 1);
    repeat (2) @(posedge rd_clk);
    #1;
    check_eq("R6 empty released by fourth read edge", int'(rd_empty), 0);
    mism = 0;
    read_words(1, 200, mism);
    check_eq("R7 next word after empty reads", mism, 0);

    // R9 almost-empty transition on the read edge
    reset_all(DEPTH, 3);
    write_words(8, 300);
    wait_rd(6);
    check_eq("R9 almost_empty clear at 8", int'(rd_almost_empty), 0);
    mism = 0;
    read_words(4, 300, mism);
    check_eq("R9 almost_empty clear at 4", int'(rd_almost_empty), 0);
    read_words(1, 304, mism);
    check_eq("R9 almost_empty set at 3", int'(rd_almost_empty), 1);

    // R2 R10 long stream with backpressure, pauses and wrap-around
    reset_all(DEPTH - 4, 4);
    begin
      int n_words = 1500;
      int bad = 0;
      int got = 0;
      fork
        begin
          int k = 0;
          while (k < n_words) begin
            @(negedge wr_clk);
            if (k % 400 == 399 && wr_en) begin
              wr_en = 1'b0;
              repeat (300) @(negedge wr_clk);
            end
            if (!wr_full) begin
              wr_en   = 1'b1;
              wr_data = pat(k);
              k++;
            end else begin
              wr_en = 1'b0;
            end
          end
          @(negedge wr_clk);
          wr_en = 1'b0;
        end
        begin
          bit took = 1'b0;
          while (got < n_words) begin
            @(negedge rd_clk);
            if (took) begin
              if (rd_data !== pat(got)) bad++;
              got++;
            end
            rd_en = !rd_empty && (got < n_words);
            took  = rd_en;
          end
          rd_en = 1'b0;
        end
      join
      check_eq("R2 stream order mismatches", bad, 0);
      check_eq("R2 stream word count", got, n_words);
      wait_rd(6);
      check_eq("R10 empty after wrapped stream", int'(rd_empty), 1);
    end

    report_and_end();
  end
endmodule